// File: doc/BRIEF.md
# Shifter operand unit with carry-out

This combinational unit forms the second ALU operand of a data-processing instruction. It takes the 32-bit instruction word, the value read for the operand register, the value read for the shift-amount register and the current carry flag. It returns the shifted or rotated operand together with the carry the shifter produces. It also flags whether the opcode belongs to the logical class, whose flag update takes its carry from the shifter and not from the adder.

Two operand sources are supported. The first is an 8-bit constant rotated right by an even amount. The second is a register value passed through one of four shift kinds. For the register source the shift amount comes either from a 5-bit field in the instruction or from the low byte of a second register. Register reads, the ALU itself and flag write-back live in neighbouring blocks.

Top module: `opnd_shifter`

## Requirements
- R1: With instruction bit 25 set, the operand is bits 7:0, zero-extended and rotated right by twice the value of bits 11:8.
- R2: In the constant form, the carry-out is bit 31 of the operand when bits 11:8 are nonzero, and is the incoming carry when they are zero.
- R3: With bit 25 and bit 4 clear, the register value is shifted by bits 11:7 (1 to 31). Bits 6:5 select the kind: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. The carry-out is the last bit shifted out, which for a rotate is result bit 31.
- R4: An instruction-field amount of 0 with kind 0 passes the register through unchanged and keeps the incoming carry.
- R5: An instruction-field amount of 0 with kind 1 gives 0. With kind 2 it fills every bit with register bit 31. In both cases the carry-out is register bit 31.
- R6: An instruction-field amount of 0 with kind 3 rotates one place right through the carry: the incoming carry enters bit 31, and register bit 0 becomes the carry-out.
- R7: With bit 25 clear and bit 4 set, the amount is bits 7:0 of the shift-amount register, and the upper bits are ignored. An amount of 0 leaves the operand and the carry unchanged.
- R8: Register amounts for the logical shifts: exactly 32 gives 0, with carry from register bit 0 (left) or bit 31 (right). Amounts above 32 give 0 with a carry of 0.
- R9: A register amount of 32 or more for the arithmetic right shift fills the operand and the carry with register bit 31.
- R10: A register rotate uses the amount modulo 32. A nonzero multiple of 32 returns the register unchanged, with carry equal to register bit 31.
- R11: The logical-class output is 1 exactly when bit 20 is set and bits 24:21 hold one of 0, 1, 8, 9, 12, 13, 14, 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_i | input | 32 | Data-processing instruction word |
| rm_val_i | input | 32 | Value of the operand register |
| rs_val_i | input | 32 | Value of the shift-amount register |
| carry_i | input | 1 | Current carry flag |
| opnd_o | output | 32 | Shifter operand |
| carry_o | output | 1 | Shifter carry-out |
| logic_flag_o | output | 1 | Logical-class opcode with set-flags bit |

## Verification
The embedded checks assume settled inputs. They also assume the word is a data-processing encoding: bit 4 set together with bit 7 set is a different instruction class, and no check covers it. The bench keeps to this by building every word from data-processing encoders. It changes all inputs together on one clock edge and reads the outputs on the opposite edge, so every check sees a settled combinational result.

// File: rtl/opnd_shifter_pkg.sv
package opnd_shifter_pkg;
  localparam int unsigned INSN_W = 32;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/opnd_rot_imm.sv
module opnd_rot_imm #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 8,
  parameter int unsigned ROT_W = 4
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic [ROT_W-1:0] rot_i,
  input  logic             carry_i,
  output logic [XLEN-1:0]  val_o,
  output logic             carry_o
);
  localparam int unsigned SHW = $clog2(XLEN);

  logic [SHW-1:0]  r;
  logic [XLEN-1:0] zx;

  always_comb begin
    r       = SHW'({rot_i, 1'b0});
    zx      = XLEN'(imm_i);
    val_o   = (zx >> r) | (zx << (XLEN - int'(r)));
    carry_o = (rot_i != '0) ? val_o[XLEN-1] : carry_i;
    a_r1_bits_kept: assert ($countones(val_o) == $countones(imm_i))
      else $error("R1: rotated constant lost bits");
    if (rot_i == '0)
      a_r2_zero_rot: assert (val_o == zx && carry_o == carry_i)
        else $error("R2: zero rotate altered value or carry");
  end
endmodule

// File: rtl/opnd_barrel.sv
module opnd_barrel
  import opnd_shifter_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned AMT_W = 8
) (
  input  logic [XLEN-1:0]  val_i,
  input  logic [AMT_W-1:0] amt_i,
  input  shift_kind_e      kind_i,
  input  logic             rrx_i,
  input  logic             carry_i,
  output logic [XLEN-1:0]  val_o,
  output logic             carry_o
);
  localparam int unsigned SHW = $clog2(XLEN);

  logic [XLEN:0]        lsl_ext, lsr_ext;
  logic signed [XLEN:0] asr_ext;
  logic [AMT_W-1:0]     asr_amt;
  logic [SHW-1:0]       r;
  logic [XLEN-1:0]      rot;

  always_comb begin
    // guard bit beside the word catches the last bit shifted out
    lsl_ext = {1'b0, val_i} << amt_i;
    lsr_ext = {val_i, 1'b0} >> amt_i;
    asr_amt = (amt_i >= AMT_W'(XLEN)) ? AMT_W'(XLEN) : amt_i;
    asr_ext = $signed({val_i, 1'b0}) >>> asr_amt;
    r       = amt_i[SHW-1:0];
    rot     = (val_i >> r) | (val_i << (XLEN - int'(r)));

    if (rrx_i) begin
      val_o   = {carry_i, val_i[XLEN-1:1]};
      carry_o = val_i[0];
    end else if (amt_i == '0) begin
      val_o   = val_i;
      carry_o = carry_i;
    end else begin
      unique case (kind_i)
        SH_LSL: begin val_o = lsl_ext[XLEN-1:0]; carry_o = lsl_ext[XLEN]; end
        SH_LSR: begin val_o = lsr_ext[XLEN:1];   carry_o = lsr_ext[0];    end
        SH_ASR: begin val_o = asr_ext[XLEN:1];   carry_o = asr_ext[0];    end
        default: begin val_o = rot;              carry_o = rot[XLEN-1];   end
      endcase
    end

    if (!rrx_i && amt_i == '0)
      a_r7_zero_amt: assert (val_o == val_i && carry_o == carry_i)
        else $error("R7: zero amount altered operand");
    if (!rrx_i && kind_i == SH_ROR)
      a_r10_ror_popcount: assert ($countones(val_o) == $countones(val_i))
        else $error("R10: rotate changed population");
    if (!rrx_i && kind_i == SH_ASR)
      a_r9_asr_sign: assert (val_o[XLEN-1] == val_i[XLEN-1])
        else $error("R9: arithmetic shift lost sign");
    if (!rrx_i && kind_i != SH_ASR && kind_i != SH_ROR && int'(amt_i) > int'(XLEN))
      a_r8_wide_logical: assert (val_o == '0 && !carry_o)
        else $error("R8: wide logical shift not cleared");
    if (rrx_i)
      a_r6_rrx_top: assert (val_o[XLEN-1] == carry_i && carry_o == val_i[0])
        else $error("R6: rotate through carry mismatch");
  end
endmodule

// File: rtl/opnd_class_dec.sv
module opnd_class_dec #(
  parameter int unsigned OP_W = 4,
  parameter logic [(1<<OP_W)-1:0] LOGIC_MASK = 16'b1111_0011_0000_0011
) (
  input  logic [OP_W-1:0] op_i,
  input  logic            set_i,
  output logic            logic_o
);
  always_comb begin
    logic_o = set_i & LOGIC_MASK[op_i];
    if (op_i inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11})
      a_r11_arith_excluded: assert (!logic_o)
        else $error("R11: arithmetic opcode marked logical");
    if (!set_i)
      a_r11_needs_set: assert (!logic_o)
        else $error("R11: flag without set bit");
  end
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import opnd_shifter_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned AMT_W = 8
) (
  input  logic [INSN_W-1:0] insn_i,
  input  logic [XLEN-1:0]   rm_val_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic              carry_i,
  output logic [XLEN-1:0]   opnd_o,
  output logic              carry_o,
  output logic              logic_flag_o
);
  localparam int unsigned IMM_W  = 8;
  localparam int unsigned ROT_W  = 4;
  localparam int unsigned FAMT_W = 5;

  logic              const_form, reg_amt;
  logic [FAMT_W-1:0] field_amt;
  shift_kind_e       kind;
  logic [AMT_W-1:0]  amt;
  logic              rrx;
  logic [XLEN-1:0]   rot_val, sh_val;
  logic              rot_c, sh_c;
  logic              unused_bits;

  assign const_form  = insn_i[25];
  assign reg_amt     = insn_i[4];
  assign field_amt   = insn_i[11:7];
  assign kind        = shift_kind_e'(insn_i[6:5]);
  assign unused_bits = ^{insn_i[31:26], insn_i[19:12], insn_i[3:0], rs_val_i[XLEN-1:AMT_W]};

  // zero field amount re-encodes as a full-width shift or as rotate-through-carry
  always_comb begin
    rrx = 1'b0;
    amt = AMT_W'(field_amt);
    if (reg_amt) begin
      amt = rs_val_i[AMT_W-1:0];
    end else if (field_amt == '0) begin
      unique case (kind)
        SH_LSL:  amt = '0;
        SH_ROR:  rrx = 1'b1;
        default: amt = AMT_W'(XLEN);
      endcase
    end
  end

  opnd_rot_imm #(.XLEN(XLEN), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
    .imm_i   (insn_i[IMM_W-1:0]),
    .rot_i   (insn_i[11:8]),
    .carry_i (carry_i),
    .val_o   (rot_val),
    .carry_o (rot_c)
  );

  opnd_barrel #(.XLEN(XLEN), .AMT_W(AMT_W)) u_barrel (
    .val_i   (rm_val_i),
    .amt_i   (amt),
    .kind_i  (kind),
    .rrx_i   (rrx),
    .carry_i (carry_i),
    .val_o   (sh_val),
    .carry_o (sh_c)
  );

  opnd_class_dec #(.OP_W(4)) u_class (
    .op_i    (insn_i[24:21]),
    .set_i   (insn_i[20]),
    .logic_o (logic_flag_o)
  );

  assign opnd_o  = const_form ? rot_val : sh_val;
  assign carry_o = const_form ? rot_c   : sh_c;

  always_comb begin
    if (const_form && insn_i[11:8] != '0)
      a_r2_const_carry: assert (carry_o == opnd_o[XLEN-1])
        else $error("R2: constant carry not bit 31");
    if (!const_form && !reg_amt && field_amt == '0 && kind == SH_LSL)
      a_r4_pass: assert (opnd_o == rm_val_i && carry_o == carry_i)
        else $error("R4: zero left shift altered operand");
    if (!const_form && !reg_amt && field_amt == '0 && (kind == SH_LSR || kind == SH_ASR))
      a_r5_full_width: assert (carry_o == rm_val_i[XLEN-1])
        else $error("R5: full-width carry mismatch");
  end
endmodule

// File: tb/opnd_shifter_tb.sv
module opnd_shifter_tb;
  import opnd_shifter_pkg::*;

  logic        clk = 1'b0;
  logic [31:0] insn, rm, rs;
  logic        cin;
  logic [31:0] opnd;
  logic        cout, lflag;
  int          n_chk = 0, n_fail = 0;
  bit          done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  opnd_shifter u_dut (
    .insn_i       (insn),
    .rm_val_i     (rm),
    .rs_val_i     (rs),
    .carry_i      (cin),
    .opnd_o       (opnd),
    .carry_o      (cout),
    .logic_flag_o (lflag)
  );

  function automatic logic [31:0] enc_k(logic [3:0] op, logic s, logic [3:0] rot, logic [7:0] imm);
    return {4'hE, 2'b00, 1'b1, op, s, 8'h00, rot, imm};
  endfunction
  function automatic logic [31:0] enc_f(logic [3:0] op, logic s, logic [4:0] a, logic [1:0] t);
    return {4'hE, 2'b00, 1'b0, op, s, 8'h00, a, t, 1'b0, 4'h0};
  endfunction
  function automatic logic [31:0] enc_r(logic [3:0] op, logic s, logic [1:0] t);
    return {4'hE, 2'b00, 1'b0, op, s, 8'h00, 4'h1, 1'b0, t, 1'b1, 4'h0};
  endfunction

  typedef struct packed {
    logic [31:0] insn;
    logic [31:0] rm;
    logic [31:0] rs;
    logic        cin;
    logic [31:0] op;
    logic        c;
    logic        fl;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{enc_k(13,1,4,8'hFF), 32'h0,        32'h0,   1'b0, 32'hFF000000, 1'b1, 1'b1, 4'd1},  // R1
    '{enc_k(13,1,0,8'h3F), 32'h0,        32'h0,   1'b1, 32'h0000003F, 1'b1, 1'b1, 4'd2},  // R2
    '{enc_k(13,1,1,8'h01), 32'h0,        32'h0,   1'b1, 32'h40000000, 1'b0, 1'b1, 4'd2},  // R2
    '{enc_f(13,1,4,0),     32'h1000000F, 32'h0,   1'b0, 32'h000000F0, 1'b1, 1'b1, 4'd3},  // R3
    '{enc_f(13,1,1,1),     32'h00000003, 32'h0,   1'b0, 32'h00000001, 1'b1, 1'b1, 4'd3},  // R3
    '{enc_f(13,1,4,2),     32'h80000010, 32'h0,   1'b1, 32'hF8000001, 1'b0, 1'b1, 4'd3},  // R3
    '{enc_f(13,1,8,3),     32'h12345678, 32'h0,   1'b1, 32'h78123456, 1'b0, 1'b1, 4'd3},  // R3
    '{enc_f(13,1,0,0),     32'hDEADBEEF, 32'h0,   1'b1, 32'hDEADBEEF, 1'b1, 1'b1, 4'd4},  // R4
    '{enc_f(13,1,0,1),     32'h80000001, 32'h0,   1'b0, 32'h00000000, 1'b1, 1'b1, 4'd5},  // R5
    '{enc_f(13,1,0,2),     32'h80000000, 32'h0,   1'b0, 32'hFFFFFFFF, 1'b1, 1'b1, 4'd5},  // R5
    '{enc_f(13,1,0,2),     32'h7FFFFFFF, 32'h0,   1'b1, 32'h00000000, 1'b0, 1'b1, 4'd5},  // R5
    '{enc_f(13,1,0,3),     32'h00000001, 32'h0,   1'b1, 32'h80000000, 1'b1, 1'b1, 4'd6},  // R6
    '{enc_f(13,1,0,3),     32'h00000002, 32'h0,   1'b0, 32'h00000001, 1'b0, 1'b1, 4'd6},  // R6
    '{enc_r(13,1,0),       32'h0000ABCD, 32'h100, 1'b1, 32'h0000ABCD, 1'b1, 1'b1, 4'd7},  // R7
    '{enc_r(13,1,0),       32'h1000000F, 32'h4,   1'b0, 32'h000000F0, 1'b1, 1'b1, 4'd7},  // R7
    '{enc_r(13,1,0),       32'h00000001, 32'd32,  1'b0, 32'h00000000, 1'b1, 1'b1, 4'd8},  // R8
    '{enc_r(13,1,1),       32'h80000000, 32'd32,  1'b0, 32'h00000000, 1'b1, 1'b1, 4'd8},  // R8
    '{enc_r(13,1,0),       32'hFFFFFFFF, 32'd33,  1'b1, 32'h00000000, 1'b0, 1'b1, 4'd8},  // R8
    '{enc_r(13,1,1),       32'hFFFFFFFF, 32'hC8,  1'b1, 32'h00000000, 1'b0, 1'b1, 4'd8},  // R8
    '{enc_r(13,1,2),       32'h80000000, 32'd40,  1'b0, 32'hFFFFFFFF, 1'b1, 1'b1, 4'd9},  // R9
    '{enc_r(13,1,2),       32'h40000000, 32'd40,  1'b1, 32'h00000000, 1'b0, 1'b1, 4'd9},  // R9
    '{enc_r(13,1,3),       32'h000000F1, 32'd36,  1'b1, 32'h1000000F, 1'b0, 1'b1, 4'd10}, // R10
    '{enc_r(13,1,3),       32'h80000000, 32'd64,  1'b0, 32'h80000000, 1'b1, 1'b1, 4'd10}, // R10
    '{enc_r(13,1,3),       32'h00000001, 32'd32,  1'b1, 32'h00000001, 1'b0, 1'b1, 4'd10}, // R10
    '{enc_f(4,1,0,0),      32'h00000005, 32'h0,   1'b0, 32'h00000005, 1'b0, 1'b0, 4'd11}, // R11
    '{enc_f(0,1,0,0),      32'h00000005, 32'h0,   1'b0, 32'h00000005, 1'b0, 1'b1, 4'd11}, // R11
    '{enc_f(13,0,0,0),     32'h00000005, 32'h0,   1'b0, 32'h00000005, 1'b0, 1'b0, 4'd11}  // R11
  };

  task automatic check(string req, logic [31:0] eo, logic ec, logic ef);
    n_chk++;
    if (opnd !== eo || cout !== ec || lflag !== ef) begin
      n_fail++;
      $display("FAIL %s: insn=%h got opnd=%h c=%b f=%b exp opnd=%h c=%b f=%b",
               req, insn, opnd, cout, lflag, eo, ec, ef);
    end
  endtask

  task automatic apply(logic [31:0] i, logic [31:0] a, logic [31:0] b, logic c);
    @(posedge clk);
    insn = i; rm = a; rs = b; cin = c;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    insn = '0; rm = '0; rs = '0; cin = 1'b0;
    // idle state: all-zero inputs give zero operand, zero carry, no flag
    @(negedge clk);
    check("R4", 32'h0, 1'b0, 1'b0);

    for (int k = 0; k < NV; k++) begin
      apply(VECS[k].insn, VECS[k].rm, VECS[k].rs, VECS[k].cin);
      check($sformatf("R%0d", VECS[k].req), VECS[k].op, VECS[k].c, VECS[k].fl);
    end

    // R3 boundary: amount 31 in both directions
    apply(enc_f(13,1,31,0), 32'h00000003, 32'h0, 1'b0);
    check("R3", 32'h80000000, 1'b1, 1'b1);
    apply(enc_f(13,1,31,1), 32'h80000000, 32'h0, 1'b1);
    check("R3", 32'h00000001, 1'b0, 1'b1);
    // R7: upper bits of the amount register ignored, rotate by 4
    apply(enc_r(13,1,3), 32'h0000000F, 32'hFFFFFF04, 1'b0);
    check("R7", 32'hF0000000, 1'b1, 1'b1);

    // R11 sweep over every opcode with set bit on
    for (int op = 0; op < 16; op++) begin
      logic exp_f;
      exp_f = (op inside {0, 1, 8, 9, 12, 13, 14, 15});
      apply(enc_f(4'(op),1,0,0), 32'h0000A5A5, 32'h0, 1'b1);
      check("R11", 32'h0000A5A5, 1'b1, exp_f);
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): got hang exp completion");
      summary();
      $finish;
    end
  end
endmodule